// File: doc/BRIEF.md
# Multithreaded Reorder Buffer

This block holds in-flight instructions for a small number of hardware threads. They share one fixed pool of entries. Each thread keeps its own program-ordered ring with its own head and tail. A producer dispatches an instruction with a sequence number and a destination tag. An execution unit later marks the entry complete by its index, and the commit stage retires the oldest instruction of a chosen thread once that instruction has completed.

The pool is split among the threads under a run-time sharing mode. In dynamic mode any active thread may take the whole pool. In partitioned mode the pool is split evenly among the active threads. In threshold mode each thread is held to a fixed percentage of the pool.

A squash request for one thread discards every instruction of that thread whose sequence number is larger than the one given. The discard walks backwards from the tail and covers at most `SQW` entries per cycle. Until the walk ends, the discarded entries stay in place, and the tail and the occupancy are left untouched. When the walk ends, the tail moves back to the youngest survivor and the freed slots are returned to the pool in a single step.

Dispatch is a valid/ready interface. `disp_ready` refers to the thread named on `disp_tid` and depends on the current state and that thread number only. A beat transfers on a cycle when both `disp_valid` and `disp_ready` are high. A beat presented while ready is low is dropped, not held. In that case the sticky `overflow` flag is set. Producers are expected to check `disp_ready` (or `free_cnt`) before driving valid.

Top module: `mt_reorder_buf`

## Requirements
- R1: After reset the buffer behaves as follows:
  - it is empty and not full, and `free_cnt` equals `E`;
  - `overflow`, `commit_ok` and all `head_ready` bits are 0;
  - all `sq_done` bits are 1.
- R2: A dispatch beat transfers when `disp_valid` and `disp_ready` are both high.
  - `disp_idx` is `{disp_tid, slot}`.
  - After reset each thread allocates slots 0, 1, 2 ... in ring order.
- R3: A beat presented with `disp_ready` low is dropped and the occupancy does not change. `overflow` goes high on the next cycle and stays high until reset.
- R4: `full` is 1 when the total occupancy equals `E`, and `empty` is 1 when the total is 0. `free_cnt` is `E` minus the total. A full buffer drives `disp_ready` low.
- R5: `thr_empty[t]` is 1 when thread t holds no entries. `thr_full[t]` is 1 when thread t holds at least its limit, and `disp_ready` is then low for thread t.
- R6: The sharing mode sets each active thread's limit. Inactive threads have limit 0.
  - `share_mode` 0 (dynamic) gives a limit of `E`.
  - 1 (partitioned) gives `E` divided by the number of active threads.
  - 2 (threshold) gives `E*PCT/100`.
  - 3 behaves like 0.
- R7: A writeback beat (`wb_valid` with `wb_idx = {tid, slot}`) marks that entry complete. `head_ready[t]` is 1 only when thread t is non-empty and its oldest entry is complete. Completing a younger entry does not set it.
- R8: `ret_req` with `ret_tid` removes that thread's oldest entry, in program order.
  - `head_seq` and `head_dst` show the entry that will be removed.
  - A retire aimed at a thread whose head is not ready is ignored.
- R9: `commit_ok` is 1 whenever any thread's `head_ready` is 1.
- R10: A squash of thread t with number S removes exactly the entries of t whose sequence number is greater than S.
  - `sq_done[t]` drops one cycle after the request and returns high after floor(n/`SQW`)+1 further cycles, where n is the number of entries removed.
  - While `sq_done[t]` is low the occupancy is unchanged.
  - Afterwards, the next slot allocated to t is the one just past the youngest survivor.
- R11: While thread t is squashing:
  - its `thr_status` field is 2;
  - `disp_ready` is low for t;
  - retires and new squash requests for t are ignored;
  - other threads keep dispatching normally.
- R12: `thr_status[2t+1:2t]` encodes the state of thread t:
  - 2 while it is squashing;
  - otherwise 1 (idle) when `thr_active[t]` is 0;
  - otherwise 0 (running).
  - An idle thread never accepts dispatch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| share_mode | input | 2 | Sharing mode: 0 dynamic, 1 partitioned, 2 threshold |
| thr_active | input | NT | Per-thread active mask |
| disp_valid | input | 1 | Dispatch beat valid |
| disp_tid | input | TW | Dispatch thread |
| disp_seq | input | SEQW | Dispatch sequence number |
| disp_dst | input | DSTW | Dispatch destination tag |
| disp_ready | output | 1 | Named thread can accept a beat |
| disp_idx | output | TW+PW | Index the beat gets, {tid, slot} |
| wb_valid | input | 1 | Completion writeback valid |
| wb_idx | input | TW+PW | Index of completed entry |
| ret_req | input | 1 | Retire the head of `ret_tid` |
| ret_tid | input | TW | Retire thread |
| sq_req | input | 1 | Squash request |
| sq_tid | input | TW | Squash thread |
| sq_seq | input | SEQW | Youngest surviving sequence number |
| sq_done | output | NT | Per-thread squash finished |
| head_ready | output | NT | Per-thread head completed |
| head_seq | output | NT*SEQW | Per-thread head sequence number |
| head_dst | output | NT*DSTW | Per-thread head destination tag |
| commit_ok | output | 1 | Some thread can retire |
| full | output | 1 | Pool fully occupied |
| empty | output | 1 | Pool unoccupied |
| thr_full | output | NT | Thread at or above its limit |
| thr_empty | output | NT | Thread holds no entries |
| free_cnt | output | CW | Free entries in the pool |
| thr_status | output | 2*NT | Per-thread state field |
| overflow | output | 1 | Sticky dropped-dispatch flag |

## Verification
The checker watches several relations on every cycle:
- the overflow flag never clears once it is set;
- full and squashing threads refuse dispatch;
- a low done flag always coincides with the squashing state;
- a ready head implies a non-empty thread;
- the free count never shrinks on a cycle with no dispatch.

Some behaviours only the bench scenarios can show:
- the program order of retired tags against a scoreboard;
- the exact limits of the three sharing modes;
- the squash boundary by sequence number and its cycle count;
- the slot reused after the tail is pulled back;
- retires that are ignored while a head is not ready.

// File: rtl/mtrob_pkg.sv
package mtrob_pkg;
  typedef enum logic [1:0] {
    ST_RUN    = 2'd0,
    ST_IDLE   = 2'd1,
    ST_SQUASH = 2'd2
  } thr_state_e;

  typedef enum logic [1:0] {
    MODE_DYN    = 2'd0,
    MODE_PART   = 2'd1,
    MODE_THRESH = 2'd2,
    MODE_RSVD   = 2'd3
  } share_mode_e;
endpackage

// File: rtl/mtrob_share_limit.sv
module mtrob_share_limit #(
  parameter int NT  = 2,
  parameter int E   = 8,
  parameter int PCT = 75,
  parameter int CW  = 4
) (
  input  logic [1:0]     mode,
  input  logic [NT-1:0]  active,
  output logic [CW-1:0]  limit [NT]
);
  import mtrob_pkg::*;

  localparam int THR_LIM = (E * PCT) / 100;

  logic [CW-1:0] part_lim;
  logic [CW-1:0] mode_lim;

  // even split among active threads, one constant divide per possible count
  always_comb begin
    part_lim = '0;
    for (int d = 1; d <= NT; d++) begin
      if ($countones(active) == d) part_lim = CW'(E / d);
    end
  end

  always_comb begin
    case (share_mode_e'(mode))
      MODE_PART:   mode_lim = part_lim;
      MODE_THRESH: mode_lim = CW'(THR_LIM);
      default:     mode_lim = CW'(E);
    endcase
  end

  generate
    for (genvar t = 0; t < NT; t++) begin : g_lim
      assign limit[t] = active[t] ? mode_lim : '0;
    end
  endgenerate
endmodule

// File: rtl/mtrob_thread_ring.sv
module mtrob_thread_ring #(
  parameter int E    = 8,
  parameter int SQW  = 2,
  parameter int SEQW = 8,
  parameter int DSTW = 6,
  parameter int PW   = 3,
  parameter int CW   = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ins_en,
  input  logic [SEQW-1:0] ins_seq,
  input  logic [DSTW-1:0] ins_dst,
  input  logic            wb_en,
  input  logic [PW-1:0]   wb_slot,
  input  logic            ret_req,
  input  logic            sq_req,
  input  logic [SEQW-1:0] sq_seq,
  output logic [CW-1:0]   cnt,
  output logic            hd_ready,
  output logic [SEQW-1:0] hd_seq,
  output logic [DSTW-1:0] hd_dst,
  output logic [PW-1:0]   tail_slot,
  output logic            squashing,
  output logic            sq_done
);
  logic [SEQW-1:0] seq_q [E];
  logic [DSTW-1:0] dst_q [E];
  logic [E-1:0]    cmpl_q;
  logic [PW-1:0]   head_q, tail_q, walk_q;
  logic [CW-1:0]   cnt_q, wcnt_q;
  logic [SEQW-1:0] sq_seq_q;
  logic            busy_q, done_q;

  logic            ret_fire, sq_fire;
  logic [PW-1:0]   tail_n;
  logic [CW-1:0]   cnt_n, remain, step_n;
  logic            walk_end;
  logic [PW-1:0]   cand;

  assign ret_fire = ret_req && hd_ready && !busy_q;
  assign sq_fire  = sq_req && !busy_q;
  assign tail_n   = ins_en ? tail_q + PW'(1) : tail_q;
  assign cnt_n    = cnt_q + (ins_en ? CW'(1) : '0) - (ret_fire ? CW'(1) : '0);
  assign remain   = cnt_q - wcnt_q;

  // backward walk: count up to SQW consecutive younger entries from walk_q
  always_comb begin
    step_n   = '0;
    walk_end = 1'b0;
    cand     = '0;
    for (int k = 0; k < SQW; k++) begin
      cand = walk_q - PW'(k + 1);
      if (!walk_end) begin
        if (CW'(k) < remain && seq_q[cand] > sq_seq_q) step_n = step_n + CW'(1);
        else walk_end = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < E; i++) begin
        seq_q[i] <= '0;
        dst_q[i] <= '0;
      end
      cmpl_q   <= '0;
      head_q   <= '0;
      tail_q   <= '0;
      walk_q   <= '0;
      cnt_q    <= '0;
      wcnt_q   <= '0;
      sq_seq_q <= '0;
      busy_q   <= 1'b0;
      done_q   <= 1'b1;
    end else begin
      if (wb_en) cmpl_q[wb_slot] <= 1'b1;
      if (ins_en) begin
        seq_q[tail_q]  <= ins_seq;
        dst_q[tail_q]  <= ins_dst;
        cmpl_q[tail_q] <= 1'b0;
      end
      if (ret_fire) head_q <= head_q + PW'(1);
      if (sq_fire) begin
        tail_q   <= tail_n;
        cnt_q    <= cnt_n;
        busy_q   <= 1'b1;
        done_q   <= 1'b0;
        walk_q   <= tail_n;
        wcnt_q   <= '0;
        sq_seq_q <= sq_seq;
      end else if (busy_q) begin
        if (walk_end) begin
          tail_q <= walk_q - PW'(step_n);
          cnt_q  <= cnt_q - wcnt_q - step_n;
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          walk_q <= walk_q - PW'(step_n);
          wcnt_q <= wcnt_q + step_n;
        end
      end else begin
        tail_q <= tail_n;
        cnt_q  <= cnt_n;
      end
    end
  end

  assign cnt       = cnt_q;
  assign hd_ready  = (cnt_q != '0) && cmpl_q[head_q];
  assign hd_seq    = seq_q[head_q];
  assign hd_dst    = dst_q[head_q];
  assign tail_slot = tail_q;
  assign squashing = busy_q;
  assign sq_done   = done_q;
endmodule

// File: rtl/mt_reorder_buf.sv
module mt_reorder_buf #(
  parameter int NT   = 2,
  parameter int E    = 8,
  parameter int SQW  = 2,
  parameter int SEQW = 8,
  parameter int DSTW = 6,
  parameter int PCT  = 75,
  localparam int PW   = $clog2(E),
  localparam int CW   = $clog2(E + 1),
  localparam int TW   = (NT > 1) ? $clog2(NT) : 1,
  localparam int IDXW = TW + PW
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         share_mode,
  input  logic [NT-1:0]      thr_active,
  input  logic               disp_valid,
  input  logic [TW-1:0]      disp_tid,
  input  logic [SEQW-1:0]    disp_seq,
  input  logic [DSTW-1:0]    disp_dst,
  output logic               disp_ready,
  output logic [IDXW-1:0]    disp_idx,
  input  logic               wb_valid,
  input  logic [IDXW-1:0]    wb_idx,
  input  logic               ret_req,
  input  logic [TW-1:0]      ret_tid,
  input  logic               sq_req,
  input  logic [TW-1:0]      sq_tid,
  input  logic [SEQW-1:0]    sq_seq,
  output logic [NT-1:0]      sq_done,
  output logic [NT-1:0]      head_ready,
  output logic [NT*SEQW-1:0] head_seq,
  output logic [NT*DSTW-1:0] head_dst,
  output logic               commit_ok,
  output logic               full,
  output logic               empty,
  output logic [NT-1:0]      thr_full,
  output logic [NT-1:0]      thr_empty,
  output logic [CW-1:0]      free_cnt,
  output logic [2*NT-1:0]    thr_status,
  output logic               overflow
);
  import mtrob_pkg::*;

  logic [CW-1:0] limit   [NT];
  logic [CW-1:0] cnt_a   [NT];
  logic [PW-1:0] tail_a  [NT];
  logic [NT-1:0] busy;
  logic [CW-1:0] total;
  logic          sel_ok;
  logic [PW-1:0] sel_tail;
  logic          ovf_q;

  mtrob_share_limit #(.NT(NT), .E(E), .PCT(PCT), .CW(CW)) u_limit (
    .mode  (share_mode),
    .active(thr_active),
    .limit (limit)
  );

  generate
    for (genvar t = 0; t < NT; t++) begin : g_thr
      logic ins_t, wb_t, ret_t, sq_t;
      assign ins_t = disp_valid && disp_ready && (disp_tid == TW'(t));
      assign wb_t  = wb_valid && (wb_idx[IDXW-1:PW] == TW'(t));
      assign ret_t = ret_req && (ret_tid == TW'(t));
      assign sq_t  = sq_req && (sq_tid == TW'(t));

      mtrob_thread_ring #(.E(E), .SQW(SQW), .SEQW(SEQW), .DSTW(DSTW),
                          .PW(PW), .CW(CW)) u_ring (
        .clk      (clk),
        .rst_n    (rst_n),
        .ins_en   (ins_t),
        .ins_seq  (disp_seq),
        .ins_dst  (disp_dst),
        .wb_en    (wb_t),
        .wb_slot  (wb_idx[PW-1:0]),
        .ret_req  (ret_t),
        .sq_req   (sq_t),
        .sq_seq   (sq_seq),
        .cnt      (cnt_a[t]),
        .hd_ready (head_ready[t]),
        .hd_seq   (head_seq[t*SEQW +: SEQW]),
        .hd_dst   (head_dst[t*DSTW +: DSTW]),
        .tail_slot(tail_a[t]),
        .squashing(busy[t]),
        .sq_done  (sq_done[t])
      );

      assign thr_empty[t] = (cnt_a[t] == '0);
      assign thr_full[t]  = (cnt_a[t] >= limit[t]);
      assign thr_status[2*t +: 2] = busy[t]          ? ST_SQUASH :
                                    !thr_active[t]   ? ST_IDLE   : ST_RUN;
    end
  endgenerate

  always_comb begin
    total = '0;
    for (int t = 0; t < NT; t++) total = total + cnt_a[t];
  end

  // admission for the thread named on disp_tid
  always_comb begin
    sel_ok   = 1'b0;
    sel_tail = '0;
    for (int t = 0; t < NT; t++) begin
      if (disp_tid == TW'(t)) begin
        sel_ok   = thr_active[t] && !busy[t] && (cnt_a[t] < limit[t]);
        sel_tail = tail_a[t];
      end
    end
  end

  assign disp_ready = sel_ok && (total < CW'(E));
  assign disp_idx   = {disp_tid, sel_tail};

  always_ff @(posedge clk) begin
    if (!rst_n) ovf_q <= 1'b0;
    else if (disp_valid && !disp_ready) ovf_q <= 1'b1;
  end

  assign overflow  = ovf_q;
  assign commit_ok = |head_ready;
  assign full      = (total == CW'(E));
  assign empty     = (total == '0);
  assign free_cnt  = CW'(E) - total;
endmodule

// File: rtl/mtrob_checker.sv
module mtrob_checker #(
  parameter int NT = 2,
  parameter int TW = 1,
  parameter int CW = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            disp_valid,
  input logic [TW-1:0]   disp_tid,
  input logic            disp_ready,
  input logic            overflow,
  input logic            full,
  input logic            empty,
  input logic            commit_ok,
  input logic [CW-1:0]   free_cnt,
  input logic [NT-1:0]   sq_done,
  input logic [NT-1:0]   head_ready,
  input logic [NT-1:0]   thr_empty,
  input logic [2*NT-1:0] thr_status
);
  import mtrob_pkg::*;

  a_r3_sticky_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

  a_r4_full_refuses: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !disp_ready);

  a_r9_commit_needs_entries: assert property (@(posedge clk) disable iff (!rst_n)
    commit_ok |-> !empty);

  // R10: occupancy can only fall (retire, squash reclaim) when nothing is offered
  a_r10_no_growth_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !disp_valid |=> free_cnt >= $past(free_cnt));

  generate
    for (genvar t = 0; t < NT; t++) begin : g_chk
      a_r10_done_low_squash: assert property (@(posedge clk) disable iff (!rst_n)
        !sq_done[t] |-> thr_status[2*t +: 2] == ST_SQUASH);

      a_r11_squash_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_tid == TW'(t) && thr_status[2*t +: 2] == ST_SQUASH) |-> !disp_ready);

      a_r7_ready_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
        head_ready[t] |-> !thr_empty[t]);
    end
  endgenerate
endmodule

bind mt_reorder_buf mtrob_checker #(.NT(NT), .TW(TW), .CW(CW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .disp_valid(disp_valid),
  .disp_tid  (disp_tid),
  .disp_ready(disp_ready),
  .overflow  (overflow),
  .full      (full),
  .empty     (empty),
  .commit_ok (commit_ok),
  .free_cnt  (free_cnt),
  .sq_done   (sq_done),
  .head_ready(head_ready),
  .thr_empty (thr_empty),
  .thr_status(thr_status)
);

// File: tb/test_mt_reorder_buf.sv
module test_mt_reorder_buf;
  localparam int NT = 2, E = 8, SQW = 2, SEQW = 8, DSTW = 6, PCT = 75;
  localparam int PW = 3, CW = 4, TW = 1, IDXW = 4;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0;
  logic [1:0] share_mode = 2'd0;
  logic [NT-1:0] thr_active = '1;
  logic disp_valid = 1'b0;
  logic [TW-1:0] disp_tid = '0;
  logic [SEQW-1:0] disp_seq = '0;
  logic [DSTW-1:0] disp_dst = '0;
  logic disp_ready;
  logic [IDXW-1:0] disp_idx;
  logic wb_valid = 1'b0;
  logic [IDXW-1:0] wb_idx = '0;
  logic ret_req = 1'b0;
  logic [TW-1:0] ret_tid = '0;
  logic sq_req = 1'b0;
  logic [TW-1:0] sq_tid = '0;
  logic [SEQW-1:0] sq_seq = '0;
  logic [NT-1:0] sq_done, head_ready, thr_full, thr_empty;
  logic [NT*SEQW-1:0] head_seq;
  logic [NT*DSTW-1:0] head_dst;
  logic commit_ok, full, empty, overflow;
  logic [CW-1:0] free_cnt;
  logic [2*NT-1:0] thr_status;

  mt_reorder_buf #(.NT(NT), .E(E), .SQW(SQW), .SEQW(SEQW), .DSTW(DSTW), .PCT(PCT))
  i_mt_reorder_buf (
    .clk(clk), .rst_n(rst_n), .share_mode(share_mode), .thr_active(thr_active),
    .disp_valid(disp_valid), .disp_tid(disp_tid), .disp_seq(disp_seq),
    .disp_dst(disp_dst), .disp_ready(disp_ready), .disp_idx(disp_idx),
    .wb_valid(wb_valid), .wb_idx(wb_idx), .ret_req(ret_req), .ret_tid(ret_tid),
    .sq_req(sq_req), .sq_tid(sq_tid), .sq_seq(sq_seq), .sq_done(sq_done),
    .head_ready(head_ready), .head_seq(head_seq), .head_dst(head_dst),
    .commit_ok(commit_ok), .full(full), .empty(empty), .thr_full(thr_full),
    .thr_empty(thr_empty), .free_cnt(free_cnt), .thr_status(thr_status),
    .overflow(overflow)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  // scoreboard: bench model of each thread's program order
  typedef struct { int seq; int dst; bit done; } item_t;
  item_t model [NT][$];
  item_t exp_ret [$];
  int    exp_tid [$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic do_reset(input logic [1:0] mode, input logic [NT-1:0] act);
    @(negedge clk);
    rst_n = 1'b0; share_mode = mode; thr_active = act;
    for (int t = 0; t < NT; t++) model[t].delete();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // starts and ends at a negedge
  task automatic dispatch(input int tid, input int seq, input int dst,
                          output bit ok, output int idx);
    disp_valid = 1'b1; disp_tid = TW'(tid);
    disp_seq = SEQW'(seq); disp_dst = DSTW'(dst);
    #1;
    ok = disp_ready; idx = int'(disp_idx);
    if (ok) model[tid].push_back('{seq: seq, dst: dst, done: 1'b0});
    @(negedge clk);
    disp_valid = 1'b0;
  endtask

  task automatic writeback(input int tid, input int slot);
    wb_valid = 1'b1; wb_idx = IDXW'(tid * E + slot);
    // model: slot position = ring index; bench tracks from head order
    @(negedge clk);
    wb_valid = 1'b0;
  endtask

  task automatic model_done(input int tid, input int seq);
    foreach (model[tid][i]) if (model[tid][i].seq == seq) model[tid][i].done = 1'b1;
  endtask

  task automatic retire(input int tid);
    if (model[tid].size() > 0 && model[tid][0].done) begin
      exp_ret.push_back(model[tid].pop_front());
      exp_tid.push_back(tid);
    end
    ret_req = 1'b1; ret_tid = TW'(tid);
    @(negedge clk);
    ret_req = 1'b0;
  endtask

  // monitor: compares retired head against the scoreboard at the edge
  always @(posedge clk) begin
    if (rst_n && ret_req && head_ready[ret_tid] &&
        thr_status[2*ret_tid +: 2] != 2'd2) begin
      if (exp_ret.size() == 0) begin
        chk(1'b0, "R8 unexpected retire", int'(ret_tid), -1);
      end else begin
        item_t it; int tt;
        it = exp_ret.pop_front(); tt = exp_tid.pop_front();
        chk(int'(ret_tid) == tt, "R8 retire thread", int'(ret_tid), tt);
        chk(int'(head_seq[ret_tid*SEQW +: SEQW]) == it.seq, "R8 retire seq",
            int'(head_seq[ret_tid*SEQW +: SEQW]), it.seq);
        chk(int'(head_dst[ret_tid*DSTW +: DSTW]) == it.dst, "R8 retire dst",
            int'(head_dst[ret_tid*DSTW +: DSTW]), it.dst);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    report();
  end

  initial begin
    bit ok; int idx; int cyc;

    // ---------- R1 reset state
    do_reset(2'd0, 2'b11);
    chk(empty && !full, "R1 empty/full", {full, empty}, 1);
    chk(free_cnt == E, "R1 free_cnt", free_cnt, E);
    chk(!overflow && !commit_ok && head_ready == 0, "R1 flags",
        {overflow, commit_ok, head_ready}, 0);
    chk(sq_done == 2'b11, "R1 sq_done", sq_done, 3);

    // ---------- R2 R7 R8 R9 out-of-order completion, in-order retire
    dispatch(0, 1, 11, ok, idx); chk(ok && idx == 0, "R2 t0 slot0", idx, 0);
    dispatch(0, 2, 12, ok, idx); chk(ok && idx == 1, "R2 t0 slot1", idx, 1);
    dispatch(0, 3, 13, ok, idx); chk(ok && idx == 2, "R2 t0 slot2", idx, 2);
    dispatch(1, 50, 40, ok, idx); chk(ok && idx == 8, "R2 t1 slot0", idx, 8);
    chk(free_cnt == 4, "R4 free after 4", free_cnt, 4);
    chk(thr_empty == 2'b00, "R5 thr_empty", thr_empty, 0);
    writeback(0, 1); model_done(0, 2);
    chk(head_ready == 2'b00 && !commit_ok, "R7 younger done not ready",
        {head_ready, commit_ok}, 0);
    retire(0);
    chk(head_seq[SEQW-1:0] == 1 && free_cnt == 4, "R8 unready retire ignored",
        head_seq[SEQW-1:0], 1);
    writeback(1, 0); model_done(1, 50);
    chk(head_ready == 2'b10 && commit_ok, "R9 commit from t1",
        {head_ready, commit_ok}, 5);
    writeback(0, 0); model_done(0, 1);
    chk(head_ready[0], "R7 head ready", head_ready[0], 1);
    retire(0);
    retire(0);
    chk(head_seq[SEQW-1:0] == 3 && !head_ready[0], "R8 head after two",
        head_seq[SEQW-1:0], 3);
    retire(1);
    chk(thr_empty[1] && free_cnt == 7, "R5 t1 empty after retire", free_cnt, 7);

    // ---------- R3 R4 R5 dynamic fill and overflow
    do_reset(2'd0, 2'b11);
    for (int i = 0; i < E; i++) dispatch(0, 20 + i, i, ok, idx);
    chk(full && free_cnt == 0 && thr_full[0], "R4 full dynamic", free_cnt, 0);
    dispatch(1, 99, 1, ok, idx);
    chk(!ok, "R4 full refuses", ok, 0);
    chk(overflow && free_cnt == 0, "R3 overflow set", overflow, 1);
    repeat (3) @(negedge clk);
    chk(overflow, "R3 overflow sticky", overflow, 1);

    // ---------- R6 partitioned
    do_reset(2'd1, 2'b11);
    for (int i = 0; i < 4; i++) dispatch(0, i, i, ok, idx);
    chk(thr_full[0] && !full && free_cnt == 4, "R6 partition limit 4", free_cnt, 4);
    dispatch(0, 9, 9, ok, idx);
    chk(!ok && overflow, "R6 partition refuses 5th", ok, 0);
    dispatch(1, 70, 7, ok, idx);
    chk(ok && idx == 8, "R6 other thread accepted", idx, 8);

    // ---------- R6 threshold
    do_reset(2'd2, 2'b11);
    for (int i = 0; i < 6; i++) dispatch(1, i, i, ok, idx);
    chk(thr_full[1] && free_cnt == 2, "R6 threshold limit 6", free_cnt, 2);
    dispatch(1, 9, 9, ok, idx);
    chk(!ok, "R6 threshold refuses 7th", ok, 0);

    // ---------- R12 idle thread
    do_reset(2'd0, 2'b01);
    chk(thr_status[3:2] == 2'd1 && thr_status[1:0] == 2'd0, "R12 status idle/run",
        thr_status, 4);
    dispatch(1, 5, 5, ok, idx);
    chk(!ok && thr_empty[1], "R12 idle refuses", ok, 0);

    // ---------- R10 R11 squash
    do_reset(2'd0, 2'b11);
    for (int i = 0; i < 6; i++) dispatch(0, 10 + i, i, ok, idx);
    writeback(0, 0); model_done(0, 10);
    sq_req = 1'b1; sq_tid = 1'b0; sq_seq = SEQW'(11);
    @(negedge clk);
    sq_req = 1'b0;
    chk(thr_status[1:0] == 2'd2 && !sq_done[0], "R11 status squash",
        thr_status[1:0], 2);
    disp_tid = 1'b0; #1;
    chk(!disp_ready, "R11 squashing thread not ready", disp_ready, 0);
    disp_tid = 1'b1; #1;
    chk(disp_ready, "R11 other thread ready", disp_ready, 1);
    cyc = 0;
    ret_req = 1'b1; ret_tid = 1'b0;
    while (!sq_done[0] && cyc < 20) begin
      chk(free_cnt == 2, "R10 occupancy held", free_cnt, 2);
      @(negedge clk);
      ret_req = 1'b0;
      cyc++;
    end
    chk(cyc == 3, "R10 squash cycles", cyc, 3);
    chk(free_cnt == 6, "R10 reclaimed", free_cnt, 6);
    chk(head_seq[SEQW-1:0] == 10 && head_ready[0], "R11 retire ignored",
        head_seq[SEQW-1:0], 10);
    while (model[0].size() > 0 && model[0][$].seq > 11) void'(model[0].pop_back());
    dispatch(0, 30, 33, ok, idx);
    chk(ok && idx == 2, "R10 tail pulled back", idx, 2);
    retire(0);
    chk(head_seq[SEQW-1:0] == 11, "R10 survivor kept", head_seq[SEQW-1:0], 11);
    writeback(0, 1); model_done(0, 11);
    retire(0);
    chk(head_seq[SEQW-1:0] == 30, "R10 new entry after survivors",
        head_seq[SEQW-1:0], 30);
    chk(exp_ret.size() == 0, "R8 scoreboard drained", exp_ret.size(), 0);

    report();
  end
endmodule